// File: doc/BRIEF.md
# Transmit Command Controller

This block sits between the command register of a CAN-style bus controller and its bit-level protocol engine. A write to the command register arrives as a one-cycle write strobe with a data byte. The block decodes the byte into a transmit request, a self-reception request, an abort, a receive-buffer release and a data-overrun clear. It then sequences the single transmit buffer through three phases: free, pending and on the bus.

Toward the protocol engine it issues a one-cycle start pulse. With the pulse it gives two held qualifiers: no-retry (single-shot) and loop-back (self-reception). The engine reports back when the frame has begun on the bus, when it has finished without fault, and when it has failed. From those reports the block keeps three status bits for software: buffer free, last transmission complete, and frame on the bus. The release and overrun-clear commands are not acted on here. They leave the block as registered one-cycle strobes for the receive path.

Top module: `txcmd_ctrl`

## Requirements
- R1: After reset the buffer-free status is 1, the transmit-complete status is 1, the on-bus status is 0, and no strobe is asserted.
- R2: Command byte bit 2 (release receive buffer) and bit 3 (clear overrun) each give a one-cycle strobe in the cycle after the write. These strobes are the only effect of the two bits.
- R3: A write with bit 0 (transmit) or bit 4 (self-reception) set is accepted when the buffer is free and reset mode is off. An accepted write pulses the start output for exactly one cycle in the cycle after the write. In that cycle buffer-free reads 0 and transmit-complete reads 0. The loop-back flag equals bit 4 of the write.
- R4: Bit 1 (abort) written together with bit 0 or bit 4 (values 0x03 and 0x12) sets the single-shot flag. Without bit 1 (0x01, 0x10) the single-shot flag is 0. Both flags hold their value while the buffer is locked.
- R5: A transmit or self-reception write is ignored while reset mode is on, or while the buffer is locked. Ignored means no start pulse and no change in status.
- R6: The engine's started report moves a pending frame onto the bus. The on-bus status is then 1 until the frame ends.
- R7: A successful finish frees the buffer, sets transmit-complete to 1 and clears on-bus, in the cycle after the report.
- R8: A failure of a frame that is not single-shot starts it again. A new start pulse follows in the next cycle, and the buffer stays locked.
- R9: A failure of a single-shot frame frees the buffer with no new start pulse, and leaves transmit-complete at 0.
- R10: An abort alone (bit 1 without bit 0 or bit 4) while a frame is pending cancels it. The buffer becomes free and transmit-complete becomes 1, and no start pulse follows.
- R11: An abort alone while a frame is on the bus does not stop the frame: on-bus stays 1. A failure of that frame is then not retried.
- R12: An abort alone while the buffer is free changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| reset_mode_i | input | 1 | Controller is in configuration (reset) mode |
| cmd_wr_i | input | 1 | Write strobe for the command register |
| cmd_data_i | input | CMD_W (8) | Command byte written |
| core_started_i | input | 1 | Protocol engine: frame has begun on the bus |
| core_done_i | input | 1 | Protocol engine: frame finished successfully |
| core_err_i | input | 1 | Protocol engine: frame failed |
| tx_start_o | output | 1 | One-cycle start pulse to the protocol engine |
| tx_single_shot_o | output | 1 | Current frame must not be retried |
| tx_self_rx_o | output | 1 | Current frame is also to be received locally |
| rx_release_o | output | 1 | One-cycle receive-buffer release strobe |
| ovr_clear_o | output | 1 | One-cycle data-overrun clear strobe |
| stat_buf_free_o | output | 1 | Transmit buffer free (0 while locked) |
| stat_tx_complete_o | output | 1 | Last transmission completed |
| stat_tx_busy_o | output | 1 | A frame is on the bus |

## Verification
The hardest case to reach from the ports is an abort that arrives while a frame is already on the bus. The frame must keep running, and the abort must only take effect later, by suppressing a retry. The stimulus reaches this case in steps. It issues a plain transmit and returns the started report. It then writes a lone abort and checks that on-bus is still set. Last, it injects a failure and checks that the buffer is released with no second start pulse. A scoreboard queue holds one expected start pulse, with its flag pair, for each acceptance or retry the stimulus intends. Any unexpected, missing or mis-flagged start pulse is therefore caught, including those that ignored requests must not produce.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Bit positions inside the command byte; software encodes against these.
  localparam int unsigned CMD_BIT_TX    = 0;
  localparam int unsigned CMD_BIT_ABORT = 1;
  localparam int unsigned CMD_BIT_REL   = 2;
  localparam int unsigned CMD_BIT_CLR   = 3;
  localparam int unsigned CMD_BIT_SRX   = 4;
  localparam int unsigned CMD_MIN_W     = 5;

  typedef enum logic [1:0] {
    TXC_IDLE = 2'd0,
    TXC_PEND = 2'd1,
    TXC_ACTV = 2'd2
  } txc_state_e;

  // Decoded command, already qualified by the write strobe.
  typedef struct packed {
    logic req;         // transmit or self-reception request
    logic self_rx;     // loop-back requested
    logic single;      // request written together with abort
    logic abort_only;  // abort without a request
    logic rel;         // release receive buffer
    logic clr;         // clear data overrun
  } txc_cmd_t;

endpackage

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
  import txc_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  output txc_cmd_t         cmd_o
);

  logic bit_tx;
  logic bit_abort;
  logic bit_rel;
  logic bit_clr;
  logic bit_srx;
  logic any_req;

  always_comb begin
    bit_tx    = cmd_data_i[CMD_BIT_TX];
    bit_abort = cmd_data_i[CMD_BIT_ABORT];
    bit_rel   = cmd_data_i[CMD_BIT_REL];
    bit_clr   = cmd_data_i[CMD_BIT_CLR];
    bit_srx   = cmd_data_i[CMD_BIT_SRX];
    any_req   = bit_tx | bit_srx;
  end

  always_comb begin
    cmd_o            = '0;
    cmd_o.req        = cmd_wr_i & any_req;
    cmd_o.self_rx    = cmd_wr_i & bit_srx;
    cmd_o.single     = cmd_wr_i & any_req & bit_abort;
    cmd_o.abort_only = cmd_wr_i & bit_abort & ~any_req;
    cmd_o.rel        = cmd_wr_i & bit_rel;
    cmd_o.clr        = cmd_wr_i & bit_clr;
  end

endmodule

// File: rtl/txc_strobe_reg.sv
module txc_strobe_reg
  import txc_pkg::*;
#(
  parameter int unsigned N_STB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_STB-1:0] stb_i,
  output logic [N_STB-1:0] stb_o
);

  logic [N_STB-1:0] stb_q;
  logic [N_STB-1:0] stb_d;
  logic             stb_en;

  // Clock enable: only load when something is set or must be cleared.
  always_comb begin
    stb_d  = stb_i;
    stb_en = (|stb_i) | (|stb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
    end else if (stb_en) begin
      stb_q <= stb_d;
    end
  end

  assign stb_o = stb_q;

  // Each strobe lasts exactly one cycle unless re-requested.
  genvar gi;
  generate
    for (gi = 0; gi < N_STB; gi++) begin : g_pulse_chk
      assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q[gi] && !stb_i[gi]) |=> !stb_q[gi]);
    end
  endgenerate

endmodule

// File: rtl/txc_tx_seq.sv
module txc_tx_seq
  import txc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reset_mode_i,
  input  txc_cmd_t cmd_i,
  input  logic     core_started_i,
  input  logic     core_done_i,
  input  logic     core_err_i,
  output logic     start_o,
  output logic     single_o,
  output logic     self_rx_o,
  output logic     buf_free_o,
  output logic     tx_complete_o,
  output logic     busy_o
);

  txc_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       single_q, single_d;
  logic       srx_q, srx_d;
  logic       noretry_q, noretry_d;
  logic       tc_q, tc_d;
  logic       flag_en;
  logic       tc_en;
  logic       nr_now;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    start_d   = 1'b0;
    single_d  = single_q;
    srx_d     = srx_q;
    noretry_d = noretry_q;
    tc_d      = tc_q;
    flag_en   = 1'b0;
    tc_en     = 1'b0;
    nr_now    = noretry_q | cmd_i.abort_only;

    unique case (state_q)
      TXC_IDLE: begin
        if (cmd_i.req && !reset_mode_i) begin
          state_d   = TXC_PEND;
          start_d   = 1'b1;
          single_d  = cmd_i.single;
          srx_d     = cmd_i.self_rx;
          noretry_d = 1'b0;
          flag_en   = 1'b1;
          tc_d      = 1'b0;
          tc_en     = 1'b1;
        end
      end
      TXC_PEND: begin
        if (core_started_i) begin
          // Already on the bus: a concurrent abort only blocks retries.
          state_d = TXC_ACTV;
          if (cmd_i.abort_only) begin
            noretry_d = 1'b1;
            flag_en   = 1'b1;
          end
        end else if (cmd_i.abort_only) begin
          state_d = TXC_IDLE;
          tc_d    = 1'b1;
          tc_en   = 1'b1;
        end
      end
      TXC_ACTV: begin
        if (cmd_i.abort_only) begin
          noretry_d = 1'b1;
          flag_en   = 1'b1;
        end
        if (core_done_i) begin
          state_d = TXC_IDLE;
          tc_d    = 1'b1;
          tc_en   = 1'b1;
        end else if (core_err_i) begin
          if (single_q || nr_now) begin
            state_d = TXC_IDLE;
          end else begin
            state_d = TXC_PEND;
            start_d = 1'b1;
          end
        end
      end
      default: begin
        state_d = TXC_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXC_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q  <= 1'b0;
      srx_q     <= 1'b0;
      noretry_q <= 1'b0;
    end else if (flag_en) begin
      single_q  <= single_d;
      srx_q     <= srx_d;
      noretry_q <= noretry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= 1'b1;
    end else if (tc_en) begin
      tc_q <= tc_d;
    end
  end

  assign start_o       = start_q;
  assign single_o      = single_q;
  assign self_rx_o     = srx_q;
  assign buf_free_o    = (state_q == TXC_IDLE);
  assign busy_o        = (state_q == TXC_ACTV);
  assign tx_complete_o = tc_q;

  // Assertions
  assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  assert_accept_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.req && !reset_mode_i && state_q == TXC_IDLE) |=> (start_q && !buf_free_o && !tc_q));

  assert_req_ignored_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.req && state_q != TXC_IDLE && !(state_q == TXC_ACTV && core_err_i)) |=> !start_q);

  assert_req_ignored_resetmode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.req && reset_mode_i && state_q == TXC_IDLE) |=> (buf_free_o && !start_q));

  assert_flags_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TXC_IDLE && state_d != TXC_IDLE) |=> ($stable(single_q) && $stable(srx_q)));

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_ACTV && core_done_i) |=> (buf_free_o && tc_q && !busy_o));

  assert_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_ACTV && core_err_i && !core_done_i && !single_q && !noretry_q
     && !cmd_i.abort_only) |=> (start_q && !buf_free_o));

  assert_single_no_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_ACTV && core_err_i && !core_done_i && single_q) |=> (buf_free_o && !start_q && !tc_q));

  assert_abort_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_PEND && cmd_i.abort_only && !core_started_i) |=> (buf_free_o && tc_q));

  assert_abort_active_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_ACTV && cmd_i.abort_only && !core_done_i && !core_err_i) |=> busy_o);

  assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXC_IDLE && cmd_i.abort_only) |=> ($stable(tc_q) && buf_free_o));

endmodule

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
  import txc_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_mode_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             core_started_i,
  input  logic             core_done_i,
  input  logic             core_err_i,
  output logic             tx_start_o,
  output logic             tx_single_shot_o,
  output logic             tx_self_rx_o,
  output logic             rx_release_o,
  output logic             ovr_clear_o,
  output logic             stat_buf_free_o,
  output logic             stat_tx_complete_o,
  output logic             stat_tx_busy_o
);

  localparam int unsigned N_FWD = 2;

  txc_cmd_t         cmd;
  logic [N_FWD-1:0] fwd_in;
  logic [N_FWD-1:0] fwd_out;

  initial begin
    if (CMD_W < CMD_MIN_W) $error("CMD_W too small for the command bit positions");
  end

  txc_cmd_decode #(
    .CMD_W (CMD_W)
  ) u_dec (
    .cmd_wr_i   (cmd_wr_i),
    .cmd_data_i (cmd_data_i),
    .cmd_o      (cmd)
  );

  assign fwd_in = {cmd.clr, cmd.rel};

  txc_strobe_reg #(
    .N_STB (N_FWD)
  ) u_fwd (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (fwd_in),
    .stb_o (fwd_out)
  );

  assign rx_release_o = fwd_out[0];
  assign ovr_clear_o  = fwd_out[1];

  txc_tx_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .reset_mode_i   (reset_mode_i),
    .cmd_i          (cmd),
    .core_started_i (core_started_i),
    .core_done_i    (core_done_i),
    .core_err_i     (core_err_i),
    .start_o        (tx_start_o),
    .single_o       (tx_single_shot_o),
    .self_rx_o      (tx_self_rx_o),
    .buf_free_o     (stat_buf_free_o),
    .tx_complete_o  (stat_tx_complete_o),
    .busy_o         (stat_tx_busy_o)
  );

  assert_release_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_data_i[CMD_BIT_REL]) |=> rx_release_o);

  assert_clear_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_data_i[CMD_BIT_CLR]) |=> ovr_clear_o);

  assert_busy_not_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_tx_busy_o && !core_done_i && !core_err_i) |=> (stat_tx_busy_o && !stat_buf_free_o));

endmodule

// File: tb/sim_txcmd_ctrl.sv
`timescale 1ns/1ps
module sim_txcmd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reset_mode;
  logic       cmd_wr;
  logic [7:0] cmd_data;
  logic       c_started, c_done, c_err;
  logic       start, ss, srx, rel, clr, bfree, tcomp, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [1:0] exp_q[$];   // expected {single_shot, self_rx} per start pulse

  always #2.5 clk = ~clk;

  txcmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reset_mode_i(reset_mode),
    .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data),
    .core_started_i(c_started), .core_done_i(c_done), .core_err_i(c_err),
    .tx_start_o(start), .tx_single_shot_o(ss), .tx_self_rx_o(srx),
    .rx_release_o(rel), .ovr_clear_o(clr),
    .stat_buf_free_o(bfree), .stat_tx_complete_o(tcomp), .stat_tx_busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Monitor: every start pulse must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && start) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R5 unexpected start", 1, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk_eq("R4 start flags {single,selfrx}", {ss, srx}, e);
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic wr_exp(input logic [7:0] v, input logic [1:0] flags);
    exp_q.push_back(flags);
    wr(v);
  endtask

  // which: 0 started, 1 done, 2 err
  task automatic core(input int which);
    @(negedge clk);
    c_started = (which == 0); c_done = (which == 1); c_err = (which == 2);
    @(negedge clk);
    c_started = 0; c_done = 0; c_err = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reset_mode = 0; cmd_wr = 0; cmd_data = 0;
    c_started = 0; c_done = 0; c_err = 0;
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    chk_eq("R1 buf_free", bfree, 1);
    chk_eq("R1 tx_complete", tcomp, 1);
    chk_eq("R1 busy", busy, 0);
    chk_eq("R1 strobes", {start, rel, clr}, 0);

    // R2 forwarded strobes
    wr(8'h04);
    chk_eq("R2 release strobe {rel,clr}", {rel, clr}, 2'b10);
    chk_eq("R2 release no tx effect", {bfree, tcomp}, 2'b11);
    idle(1);
    chk_eq("R2 release one cycle", rel, 0);
    wr(8'h08);
    chk_eq("R2 clear strobe {rel,clr}", {rel, clr}, 2'b01);

    // R3 plain transmit
    wr_exp(8'h01, 2'b00);
    chk_eq("R3 start pulse", start, 1);
    chk_eq("R3 buffer locked", bfree, 0);
    chk_eq("R3 tc cleared", tcomp, 0);
    idle(1);
    chk_eq("R3 start single cycle", start, 0);
    // R5 request while locked
    wr(8'h10);
    chk_eq("R5 locked request ignored", bfree, 0);
    chk_eq("R5 locked selfrx flag kept", srx, 0);
    // R6 started
    core(0);
    chk_eq("R6 busy after started", busy, 1);
    idle(2);
    chk_eq("R6 busy held", busy, 1);
    // R7 done
    core(1);
    chk_eq("R7 buffer free", bfree, 1);
    chk_eq("R7 tc set", tcomp, 1);
    chk_eq("R7 busy clear", busy, 0);

    // R8 retry of self-reception frame
    wr_exp(8'h10, 2'b01);
    chk_eq("R4 selfrx flag", {ss, srx}, 2'b01);
    core(0);
    exp_q.push_back(2'b01);
    core(2);
    chk_eq("R8 retry start", start, 1);
    chk_eq("R8 buffer still locked", bfree, 0);
    core(0);
    core(1);
    chk_eq("R8 done after retry", {bfree, tcomp}, 2'b11);

    // R9 single-shot failure
    wr_exp(8'h03, 2'b10);
    chk_eq("R4 single-shot flag", {ss, srx}, 2'b10);
    core(0);
    core(2);
    chk_eq("R9 buffer free", bfree, 1);
    chk_eq("R9 tc stays 0", tcomp, 0);
    chk_eq("R9 no retry start", start, 0);
    idle(2);

    // R12 abort while idle
    wr(8'h02);
    chk_eq("R12 idle abort tc unchanged", tcomp, 0);
    chk_eq("R12 idle abort buffer free", bfree, 1);
    idle(2);

    // single-shot self-reception
    wr_exp(8'h12, 2'b11);
    chk_eq("R4 single selfrx flags", {ss, srx}, 2'b11);
    core(0);
    core(1);
    chk_eq("R7 single selfrx done", {bfree, tcomp}, 2'b11);

    // R5 reset mode
    reset_mode = 1;
    wr(8'h01);
    chk_eq("R5 reset-mode request ignored", bfree, 1);
    idle(2);
    reset_mode = 0;

    // R10 abort pending frame
    wr_exp(8'h01, 2'b00);
    chk_eq("R10 pending tc 0", tcomp, 0);
    wr(8'h02);
    chk_eq("R10 abort frees buffer", bfree, 1);
    chk_eq("R10 abort sets tc", tcomp, 1);
    idle(3);

    // R11 abort while on bus
    wr_exp(8'h01, 2'b00);
    core(0);
    wr(8'h02);
    chk_eq("R11 frame continues", busy, 1);
    chk_eq("R11 buffer locked", bfree, 0);
    core(2);
    chk_eq("R11 no retry after abort", start, 0);
    chk_eq("R11 buffer free after failure", bfree, 1);
    idle(3);

    chk_eq("R3 all expected starts seen", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule